// File: doc/BRIEF.md
# Bus-Master Request and Lock Sequencer

This block is the request-side controller of a bus master on a shared, arbitrated bus. A local transfer engine hands it one operation at a time: a start pulse plus a descriptor giving the class (single, fixed-length burst or open-ended incrementing burst), the beat count and whether the operation is locked. The sequencer then drives the bus request and lock request lines. It follows grant and ready to know when the master owns the address bus. It signals the engine, one beat per cycle, when an address phase may be presented.

The sequencer tracks ownership in the usual way. The master owns the next address phase only after an edge where grant and ready were both high. While ready is low, ownership does not change. When the request line drops depends on the burst class. For a locked operation the lock line is raised one cycle ahead of the first address phase and dropped at the start of the last one. If a counted burst loses ownership after a beat, the engine is told to carry on later from the next unissued beat as an incrementing transfer. The issued-beat count is kept.

States: `ST_IDLE` (no operation), `ST_LEAD` (one cycle of lock and request before a locked operation), `ST_RUN` (beats being issued whenever owned) and `ST_DONE` (one-cycle completion). Transitions: IDLE→LEAD on an accepted start with lock set; IDLE→RUN on an accepted start without lock; LEAD→RUN always; RUN→DONE when the final beat is accepted; DONE→IDLE always.

Top module: `bm_req_seq`

## Requirements
- R1: After reset and whenever idle, bus_req_o, bus_lock_o, issue_o, done_o and resume_o are all low, and issued_o reads 0 after reset.
- R2: A start pulse is taken only in the idle state. A start pulse while an operation runs is ignored, and the running operation completes with its own beat count.
- R3: The master owns the address bus in the cycle after an edge where grant_i and ready_i are both high. It loses ownership after an edge where ready_i is high and grant_i low. On edges with ready_i low, ownership is unchanged. issue_o is high exactly in running cycles with ownership, and a beat is accepted at an edge where issue_o and ready_i are both high.
- R4: An unlocked operation started while ownership is already held issues its first beat in the first cycle after the start pulse.
- R5: For a locked operation, bus_req_o and bus_lock_o are high for one cycle with issue_o low, immediately before the running phase. Ownership in that cycle does not change this.
- R6: During a locked operation, bus_lock_o stays high up to the last address phase. It is low from the cycle in which the final beat is issued.
- R7: For an open-ended incrementing burst (kind_i[1] = 1), bus_req_o is high in every running cycle except those in which the final beat is issued.
- R8: For single and fixed-length bursts (kind_i = 00 and 01), bus_req_o is high in running cycles without ownership and low in owned cycles. The exception is R9.
- R9: If a single or fixed-length operation finds ownership already held in its first running cycle without having requested, bus_req_o stays high for the rest of that operation.
- R10: done_o pulses for one cycle, in the cycle after the edge that accepts the final beat. issued_o holds the number of accepted beats until the next start.
- R11: When a non-final beat is accepted at an edge where grant_i is low, resume_o pulses in the next cycle. issued_o keeps its value, and the remaining beats are issued once ownership returns.
- R12: A single (kind_i = 00) always runs one beat whatever len_i holds, and a length of 0 for the other kinds runs one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a new operation |
| kind_i | input | 2 | 00 single, 01 fixed-length burst, 1x open-ended incrementing burst |
| len_i | input | LEN_W | Beat count of the operation |
| lock_i | input | 1 | Operation is locked |
| issue_o | output | 1 | Engine may present an address phase this cycle |
| done_o | output | 1 | Final beat accepted (one-cycle pulse) |
| resume_o | output | 1 | Ownership lost mid-burst; continue later as incrementing |
| issued_o | output | LEN_W | Beats accepted in the current or last operation |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_lock_o | output | 1 | Lock request to the arbiter |
| grant_i | input | 1 | Grant from the arbiter |
| ready_i | input | 1 | Bus ready |

## Verification
The embedded properties rely on the arbiter not withdrawing grant during a locked operation, and on start being a single-cycle pulse. The lock-release property also depends on every beat eventually being accepted, so ready must not stay low forever. The stimulus keeps to these rules. Grant is removed only during an unlocked fixed-length burst, and every ready-low stall lasts one cycle. Stalls and grant changes are placed on ready-low edges, and one start pulse lands in the middle of a running burst, so that ownership hold and start rejection are observed at the outputs.

// File: rtl/bmrs_pkg.sv
package bmrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    localparam logic [1:0] KIND_SINGLE = 2'b00;
    localparam logic [1:0] KIND_FIXED  = 2'b01;

endpackage

// File: rtl/bmrs_own_track.sv
module bmrs_own_track (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic ready_i,
    output logic own_o
);

    logic own_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= 1'b0;
        end else if (ready_i) begin
            own_q <= grant_i;
        end
    end

    assign own_o = own_q;

    AST_OWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(own_o)); // R3

endmodule

// File: rtl/bmrs_beat_cnt.sv
module bmrs_beat_cnt #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_len_i,
    input  logic             dec_i,
    output logic             last_o,
    output logic [LEN_W-1:0] issued_o
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] done_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q      <= '0;
            done_cnt_q <= '0;
        end else if (load_i) begin
            rem_q      <= load_len_i;
            done_cnt_q <= '0;
        end else if (dec_i) begin
            rem_q      <= rem_q - ONE;
            done_cnt_q <= done_cnt_q + ONE;
        end
    end

    assign last_o   = (rem_q == ONE);
    assign issued_o = done_cnt_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (rem_q != '0)); // R10

endmodule

// File: rtl/bmrs_line_ctl.sv
module bmrs_line_ctl (
    input  logic run_i,
    input  logic lead_i,
    input  logic open_i,
    input  logic locked_i,
    input  logic own_i,
    input  logic last_i,
    input  logic first_i,
    input  logic sticky_i,
    output logic req_o,
    output logic lock_o
);

    logic final_phase;
    logic counted_req;

    always_comb begin
        final_phase = own_i && last_i;
        counted_req = sticky_i || (first_i && own_i) || !own_i;
        req_o  = lead_i || (run_i && (open_i ? !final_phase : counted_req));
        lock_o = lead_i || (run_i && locked_i && !final_phase);
    end

endmodule

// File: rtl/bm_req_seq.sv
module bm_req_seq
    import bmrs_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       kind_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             lock_i,
    output logic             issue_o,
    output logic             done_o,
    output logic             resume_o,
    output logic [LEN_W-1:0] issued_o,
    output logic             bus_req_o,
    output logic             bus_lock_o,
    input  logic             grant_i,
    input  logic             ready_i
);

    localparam logic [LEN_W-1:0] ONE_BEAT = LEN_W'(1);

    seq_state_t       state_q, state_d;
    logic             open_q, lk_q, first_q, sticky_q;
    logic             done_q, resume_q;
    logic             own, last, accept, start_ok;
    logic [LEN_W-1:0] len_eff;

    bmrs_own_track u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant_i),
        .ready_i (ready_i),
        .own_o   (own)
    );

    bmrs_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_ok),
        .load_len_i (len_eff),
        .dec_i      (accept),
        .last_o     (last),
        .issued_o   (issued_o)
    );

    bmrs_line_ctl u_lines (
        .run_i    (state_q == ST_RUN),
        .lead_i   (state_q == ST_LEAD),
        .open_i   (open_q),
        .locked_i (lk_q),
        .own_i    (own),
        .last_i   (last),
        .first_i  (first_q),
        .sticky_i (sticky_q),
        .req_o    (bus_req_o),
        .lock_o   (bus_lock_o)
    );

    always_comb begin
        start_ok = start_i && (state_q == ST_IDLE);
        accept   = (state_q == ST_RUN) && own && ready_i;
        if ((kind_i == KIND_SINGLE) || (len_i == '0)) begin
            len_eff = ONE_BEAT;
        end else begin
            len_eff = len_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = lock_i ? ST_LEAD : ST_RUN;
            ST_LEAD: state_d = ST_RUN;
            ST_RUN:  if (accept && last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-operation flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            open_q   <= 1'b0;
            lk_q     <= 1'b0;
            first_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= start_ok && !lock_i;
            if (start_ok) begin
                open_q   <= kind_i[1];
                lk_q     <= lock_i;
                sticky_q <= 1'b0;
            end else if (first_q && own) begin
                sticky_q <= 1'b1;
            end
        end
    end

    // registered engine-facing pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            done_q   <= accept && last;
            resume_q <= accept && !last && !grant_i;
        end
    end

    assign issue_o  = (state_q == ST_RUN) && own;
    assign done_o   = done_q;
    assign resume_o = resume_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!bus_req_o && !bus_lock_o && !issue_o)); // R1
    AST_LOCK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && lk_q && (issued_o == '0)) |-> $past(bus_lock_o)); // R5
    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock_o) |-> (issue_o && last)); // R6
    AST_OPEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && open_q && !last) |-> bus_req_o); // R7
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_RESUME_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> !issue_o); // R11

endmodule

// File: tb/tb_bm_req_seq.sv
`timescale 1ns/1ps
module tb_bm_req_seq;

    localparam int LEN_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [1:0]       kind_i = 2'b00;
    logic [LEN_W-1:0] len_i = '0;
    logic             lock_i = 1'b0;
    logic             grant_i = 1'b0;
    logic             ready_i = 1'b0;
    logic             issue_o, done_o, resume_o, bus_req_o, bus_lock_o;
    logic [LEN_W-1:0] issued_o;

    always #2.5 clk = ~clk;

    bm_req_seq #(.LEN_W(LEN_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .kind_i     (kind_i),
        .len_i      (len_i),
        .lock_i     (lock_i),
        .issue_o    (issue_o),
        .done_o     (done_o),
        .resume_o   (resume_o),
        .issued_o   (issued_o),
        .bus_req_o  (bus_req_o),
        .bus_lock_o (bus_lock_o),
        .grant_i    (grant_i),
        .ready_i    (ready_i)
    );

    typedef struct {
        logic [4:0]       vec;
        logic             chk_cnt;
        logic [LEN_W-1:0] cnt;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    logic             cnt_pend = 1'b0;
    logic [LEN_W-1:0] cnt_val = '0;

    // expected lines {req, lock, issue, done, resume} for the current cycle;
    // inputs set here are sampled at the next rising edge
    task automatic step(input logic g, input logic r, input logic s,
                        input logic [4:0] v, input string tag);
        exp_t it;
        @(posedge clk);
        #1;
        grant_i = g;
        ready_i = r;
        start_i = s;
        it.vec = v;
        it.chk_cnt = cnt_pend;
        it.cnt = cnt_val;
        it.tag = tag;
        cnt_pend = 1'b0;
        exp_q.push_back(it);
    endtask

    task automatic desc(input logic [1:0] k, input logic [LEN_W-1:0] n, input logic lk);
        kind_i = k;
        len_i  = n;
        lock_i = lk;
    endtask

    task automatic want_cnt(input logic [LEN_W-1:0] n);
        cnt_pend = 1'b1;
        cnt_val  = n;
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            logic [4:0] act;
            it = exp_q.pop_front();
            act = {bus_req_o, bus_lock_o, issue_o, done_o, resume_o};
            checks++;
            if (act !== it.vec) begin
                errors++;
                $display("FAIL %s lines req/lock/issue/done/resume actual=%b expected=%b",
                         it.tag, act, it.vec);
            end
            if (it.chk_cnt) begin
                checks++;
                if (issued_o !== it.cnt) begin
                    errors++;
                    $display("FAIL %s issued_o actual=%0d expected=%0d",
                             it.tag, issued_o, it.cnt);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // open-ended incrementing burst, 3 beats, not owned at start
        desc(2'b10, 5'd3, 1'b0);
        want_cnt(5'd0);
        step(0, 1, 1, 5'b00000, "R1");
        step(1, 1, 0, 5'b10000, "R7");
        step(1, 1, 0, 5'b10100, "R7");
        step(1, 1, 0, 5'b10100, "R3");
        step(1, 1, 0, 5'b00100, "R7");
        step(1, 1, 0, 5'b00010, "R10");

        // single with default ownership, len field ignored
        desc(2'b00, 5'd7, 1'b0);
        want_cnt(5'd3);
        step(1, 1, 1, 5'b00000, "R10");
        step(1, 1, 0, 5'b10100, "R4");
        step(1, 1, 0, 5'b00010, "R12");

        // fixed 3 beats on unrequested grant; start mid-burst ignored
        desc(2'b01, 5'd3, 1'b0);
        want_cnt(5'd1);
        step(1, 1, 1, 5'b00000, "R12");
        step(1, 1, 0, 5'b10100, "R9");
        desc(2'b10, 5'd9, 1'b0);
        step(1, 1, 1, 5'b10100, "R9");
        step(1, 1, 0, 5'b10100, "R9");
        step(1, 1, 0, 5'b00010, "R2");

        // fixed 4 beats: request until owned, stall, loss and resume
        want_cnt(5'd3);
        step(0, 1, 0, 5'b00000, "R2");
        desc(2'b01, 5'd4, 1'b0);
        step(0, 1, 1, 5'b00000, "R1");
        step(1, 0, 0, 5'b10000, "R8");
        step(1, 1, 0, 5'b10000, "R3");
        step(0, 0, 0, 5'b00100, "R8");
        step(0, 1, 0, 5'b00100, "R3");
        step(0, 1, 0, 5'b10001, "R11");
        want_cnt(5'd1);
        step(1, 1, 0, 5'b10000, "R11");
        step(1, 1, 0, 5'b00100, "R11");
        step(1, 1, 0, 5'b00100, "R8");
        step(1, 1, 0, 5'b00100, "R8");
        step(1, 1, 0, 5'b00010, "R11");

        // locked open-ended burst, 3 beats, owned by default
        desc(2'b10, 5'd3, 1'b1);
        want_cnt(5'd4);
        step(1, 1, 1, 5'b00000, "R11");
        step(1, 1, 0, 5'b11000, "R5");
        step(1, 1, 0, 5'b11100, "R6");
        step(1, 1, 0, 5'b11100, "R6");
        step(1, 0, 0, 5'b00100, "R6");
        step(1, 1, 0, 5'b00100, "R7");
        step(1, 1, 0, 5'b00010, "R10");

        // fixed with zero length runs one beat
        desc(2'b01, 5'd0, 1'b0);
        want_cnt(5'd3);
        step(1, 1, 1, 5'b00000, "R10");
        step(1, 1, 0, 5'b10100, "R12");
        step(1, 1, 0, 5'b00010, "R12");
        want_cnt(5'd1);
        step(1, 1, 0, 5'b00000, "R12");

        @(posedge clk);
        @(negedge clk);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule